// File: doc/BRIEF.md
# Transmit Checksum Offload Parser

This block sits in a transmit path. Each frame it receives begins with an 8-byte control prefix, and the prefix asks for per-protocol checksum work on the frame. The block stores the whole frame in an internal byte buffer and decodes the prefix. It then updates header fields in place: it computes and inserts an IPv4 header checksum, or it clears the UDP checksum field. Finally it sends the frame out with the 8 prefix bytes removed. While it does this it holds `in_ready` low. Some work is left to a later stage: full TCP or UDP checksums over the payload and pseudo-header. For that work the block raises a request flag that runs alongside the outgoing frame.

Both streams move one byte per cycle, with start and end markers. A frame is accepted while `in_ready` is high. Once the end byte is taken, the block works through its decode, sum and patch steps. It then sends the stripped frame as an unbroken burst.

Top module: `tx_ofl_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The output frame is input bytes 8 through the last byte, in order. `out_sop` is set on the first output byte and `out_eop` on the last, and `out_valid` is continuous between them.
- R3: Prefix byte 0 is the flag byte. When flag bit 7 (IPv4) and bit 4 (insert IP checksum) are both set, the IPv4 header gets a new checksum. The header starts at frame byte 8 + prefix byte 3, and its length is 4 × the low nibble of its first byte. The checksum is the one's complement of the one's-complement sum of the header's big-endian 16-bit words, skipping the word at header bytes 10–11. It is written to bytes 10 (high) and 11 (low).
- R4: If bit 7 or bit 4 is clear, the IPv4 header goes out unchanged.
- R5: When bits 7, 6 (L4 present) and 5 (UDP) are set and bit 3 (L4 checksum request) is clear, the bytes at L4 header offsets 6 and 7 are zeroed. The L4 header starts at the L3 header start + prefix byte 2.
- R6: `l4_udp_req` is 1 while the frame is output when bits 7, 6, 5 and 3 are all set. `l4_tcp_req` is 1 when bits 7, 6 and 3 are set and bit 5 is clear. Both flags are 0 when `out_valid` is 0.
- R7: `in_ready` is 0 from the cycle after the end byte is accepted until the cycle after the last output byte. Input offered during that time is ignored.
- R8: The first output byte appears 2 cycles after the edge that accepts the end byte. When the IPv4 checksum is performed, it appears 2 + 2 × IHL cycles after that edge.
- R9: Only the first DEPTH bytes of a frame are stored, so a longer frame leaves the block truncated to DEPTH − 8 bytes. A frame of 8 bytes or fewer produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of input frame |
| in_eop | input | 1 | Last byte of input frame |
| in_ready | output | 1 | Block accepts input |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of output frame |
| out_eop | output | 1 | Last byte of output frame |
| l4_udp_req | output | 1 | UDP checksum requested for the current output frame |
| l4_tcp_req | output | 1 | TCP checksum requested for the current output frame |

## Verification
The output burst starts a fixed number of cycles after the edge that takes the end byte. That is 2 cycles for a frame with no IPv4 checksum work, or 2 + 2 × IHL cycles when the header is summed, one cycle per 16-bit word. After that edge the bench counts edges and samples at each falling edge. It requires the first `out_valid` on exactly the computed count, and also that `in_ready` stays low until then. From there it expects one byte per cycle. One cycle after `out_eop` it expects `out_valid` low and `in_ready` high again.

// File: rtl/tx_ofl_parser.sv
`timescale 1ns/1ps
module tx_ofl_parser #(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       l4_udp_req,
  output logic       l4_tcp_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = (AW + 1 > 10) ? AW + 1 : 10;

  typedef enum logic [2:0] {S_RX, S_DEC, S_SUM, S_FIX, S_TX} st_t;
  st_t st;

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] cnt, len, ptr, idx;
  logic [5:0]    wi;
  logic [15:0]   acc;

  function automatic logic [7:0] rdb(input logic [IW-1:0] a);
    rdb = (a < IW'(DEPTH)) ? mem[a[AW-1:0]] : 8'h00;
  endfunction

  wire [7:0]    flg   = mem[0];
  wire [IW-1:0] l3    = IW'(8) + IW'(mem[3]);
  wire [IW-1:0] l4    = l3 + IW'(mem[2]);
  wire [7:0]    hb    = rdb(l3);
  wire [5:0]    nwrd  = {1'b0, hb[3:0], 1'b0};
  wire          do_ip = flg[7] & flg[4];
  wire          do_z  = flg[7] & flg[6] & flg[5] & ~flg[3];
  wire [IW-1:0] wa    = l3 + IW'({wi, 1'b0});
  wire [15:0]   word  = {rdb(wa), rdb(wa + IW'(1))};
  wire [16:0]   s17   = {1'b0, acc} + {1'b0, word};
  wire [15:0]   csum  = ~acc;

  assign idx        = in_sop ? '0 : cnt;
  assign in_ready   = (st == S_RX);
  assign out_valid  = (st == S_TX);
  assign out_data   = rdb(ptr);
  assign out_sop    = out_valid && (ptr == IW'(8));
  assign out_eop    = out_valid && (ptr == len - IW'(1));
  assign l4_udp_req = out_valid & flg[7] & flg[6] & flg[5] & flg[3];
  assign l4_tcp_req = out_valid & flg[7] & flg[6] & ~flg[5] & flg[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RX; cnt <= '0; len <= '0; ptr <= '0; wi <= '0; acc <= '0;
    end else begin
      case (st)
        S_RX: if (in_valid) begin
          cnt <= (idx < IW'(DEPTH)) ? idx + IW'(1) : idx;
          if (in_eop) begin
            len <= (idx < IW'(DEPTH)) ? idx + IW'(1) : idx;
            st  <= S_DEC;
          end
        end
        S_DEC: begin
          wi  <= '0;
          acc <= '0;
          st  <= do_ip ? S_SUM : S_FIX;
        end
        S_SUM: begin
          if (wi != 6'd5) acc <= s17[15:0] + {15'd0, s17[16]};
          wi <= wi + 6'd1;
          if (wi + 6'd1 >= nwrd) st <= S_FIX;
        end
        S_FIX: begin
          ptr <= IW'(8);
          cnt <= '0;
          st  <= (len > IW'(8)) ? S_TX : S_RX;
        end
        S_TX: begin
          ptr <= ptr + IW'(1);
          if (ptr == len - IW'(1)) st <= S_RX;
        end
        default: st <= S_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_RX && in_valid && idx < IW'(DEPTH))
      mem[idx[AW-1:0]] <= in_data;
    if (st == S_FIX) begin
      if (do_ip && (l3 + IW'(11)) < IW'(DEPTH)) begin
        mem[AW'(l3 + IW'(10))] <= csum[15:8];
        mem[AW'(l3 + IW'(11))] <= csum[7:0];
      end
      if (do_z && (l4 + IW'(7)) < IW'(DEPTH)) begin
        mem[AW'(l4 + IW'(6))] <= 8'h00;
        mem[AW'(l4 + IW'(7))] <= 8'h00;
      end
    end
  end
endmodule

module tx_ofl_parser_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_sop,
  input logic out_eop,
  input logic l4_udp_req,
  input logic l4_tcp_req
);
  p_ready_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_ready_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |=> (in_ready && !out_valid));
  p_burst_cont_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |=> out_valid);
  p_sop_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sop);
  p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(l4_udp_req && l4_tcp_req));
  p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> ($stable(l4_udp_req) && $stable(l4_tcp_req)));
  p_req_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!l4_udp_req && !l4_tcp_req));
endmodule

bind tx_ofl_parser tx_ofl_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
  .l4_udp_req(l4_udp_req), .l4_tcp_req(l4_tcp_req)
);

// File: tb/tb_tx_ofl_parser.sv
`timescale 1ns/1ps
module tb_tx_ofl_parser;
  localparam int DEPTH = 128;
  localparam int NV = 9;
  // flags | l3 offset | l4 offset | IHL | length
  localparam logic [43:0] VEC [NV] = '{
    44'h00_00_14_5_003C, 44'h90_00_14_5_003C, 44'h90_0E_14_6_0050,
    44'hE0_0E_14_5_0046, 44'hE8_0E_14_5_0046, 44'hC8_0E_14_5_0046,
    44'hF0_02_14_5_0040, 44'h78_00_14_5_0040, 44'h80_00_14_5_0032
  };

  logic clk = 0;
  always #2.5 clk = ~clk;
  logic rst_n, in_valid, in_sop, in_eop;
  logic [7:0] in_data;
  logic in_ready, out_valid, out_sop, out_eop, l4_udp_req, l4_tcp_req;
  logic [7:0] out_data;

  tx_ofl_parser #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .l4_udp_req(l4_udp_req), .l4_tcp_req(l4_tcp_req)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] fr [300];
  logic [7:0] mb [300];
  logic [7:0] got [300];
  int ex_len, eff;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mget(input int a);
    return (a < eff) ? mb[a] : 8'h00;
  endfunction

  function automatic logic [15:0] fold_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  task automatic run(input logic [7:0] f, input int l3, input int l4, input int ihl, input int len);
    int base, k, ix, lat;
    bit udp_e, tcp_e, do_ip, do_z, leak;
    logic [15:0] s;
    base  = 8 + l3;
    do_ip = f[7] & f[4];
    do_z  = f[7] & f[6] & f[5] & ~f[3];
    udp_e = f[7] & f[6] & f[5] & f[3];
    tcp_e = f[7] & f[6] & ~f[5] & f[3];
    for (int i = 0; i < len; i++) fr[i] = 8'((i * 29 + 7) & 255);
    fr[0] = f; fr[1] = 8'h00; fr[2] = 8'(l4); fr[3] = 8'(l3);
    if (base < len) fr[base] = 8'h40 | 8'(ihl);
    eff = (len < DEPTH) ? len : DEPTH;
    for (int i = 0; i < eff; i++) mb[i] = fr[i];
    if (do_ip) begin
      s = 16'h0;
      for (int w = 0; w < 2 * ihl; w++)
        if (w != 5) s = fold_add(s, {mget(base + 2 * w), mget(base + 2 * w + 1)});
      if (base + 11 < eff) begin mb[base + 10] = ~s[15:8]; mb[base + 11] = ~s[7:0]; end
    end
    if (do_z && base + l4 + 7 < eff) begin mb[base + l4 + 6] = 0; mb[base + l4 + 7] = 0; end
    ex_len = (eff > 8) ? eff - 8 : 0;
    lat = do_ip ? 2 + 2 * ihl : 2;

    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = fr[i]; in_sop = (i == 0); in_eop = (i == len - 1);
    end
    @(posedge clk);
    @(negedge clk);
    if (ex_len == 0) begin
      in_valid = 0;
      leak = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (out_valid) leak = 1;
      end
      chk(!leak, "R9 short frame no output", leak, 0);
      chk(in_ready == 1, "R9 short frame ready", in_ready, 1);
      return;
    end
    in_valid = 1; in_data = 8'hEE; in_sop = 1; in_eop = 1;
    k = 0; leak = 0;
    while (!out_valid && k < 200) begin
      if (k > 0 && in_ready) leak = 1;
      @(posedge clk); @(negedge clk);
      k++;
    end
    chk(k == lat, "R8 first output latency", k, lat);
    chk(!leak, "R7 ready low while processing", leak, 0);
    ix = 0;
    while (1) begin
      got[ix] = out_data;
      chk(out_valid, "R2 continuous burst", out_valid, 1);
      chk(out_data == mb[ix + 8], "R2/R3/R5 output byte", out_data, mb[ix + 8]);
      chk(out_sop == (ix == 0), "R2 sop marker", out_sop, ix == 0);
      chk(out_eop == (ix == ex_len - 1), "R2 eop marker", out_eop, ix == ex_len - 1);
      chk(!in_ready, "R7 ready low during output", in_ready, 0);
      if (ix == 0) begin
        chk(l4_udp_req == udp_e, "R6 udp request", l4_udp_req, udp_e);
        chk(l4_tcp_req == tcp_e, "R6 tcp request", l4_tcp_req, tcp_e);
      end
      if (out_eop || ix >= ex_len) begin in_valid = 0; break; end
      @(posedge clk); @(negedge clk);
      ix++;
    end
    chk(ix == ex_len - 1, "R2 R9 output length", ix + 1, ex_len);
    @(posedge clk); @(negedge clk);
    chk(!out_valid && in_ready, "R7 ready back after frame", {out_valid, in_ready}, 1);
    if (do_ip && l3 + 4 * ihl <= ex_len) begin
      s = 16'h0;
      for (int w = 0; w < 2 * ihl; w++) s = fold_add(s, {got[l3 + 2 * w], got[l3 + 2 * w + 1]});
      chk(s == 16'hFFFF, "R3 header verifies", s, 16'hFFFF);
    end
    if (!do_ip && base + 11 < eff)
      chk({got[l3 + 10], got[l3 + 11]} == {fr[base + 10], fr[base + 11]},
          "R4 checksum field untouched", {got[l3 + 10], got[l3 + 11]}, {fr[base + 10], fr[base + 11]});
  endtask

  initial begin
    #(5 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; in_sop = 0; in_eop = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1 reset ready", in_ready, 1);
    chk(out_valid == 0, "R1 reset no output", out_valid, 0);
    for (int v = 0; v < NV; v++)
      run(VEC[v][43:36], int'(VEC[v][35:28]), int'(VEC[v][27:20]),
          int'(VEC[v][19:16]), int'(VEC[v][15:0]));
    // R9 oversize frame truncated, checksum still done
    run(8'h90, 0, 20, 5, 140);
    // R9 frame of only control bytes
    run(8'h90, 0, 20, 5, 6);
    // R3 larger header with offset, R6 tcp with checksum
    run(8'hD8, 4, 24, 7, 90);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule